// File: doc/BRIEF.md
# Flash Line Prefetch Read Controller

This block serves instruction fetches from a wide, slow flash array. Every array access returns one 128-bit line after a programmable number of wait states. The block keeps the most recent line in a current-line buffer and answers 32-bit or 16-bit fetches that fall inside that line one cycle after they are accepted, without touching the array. A fetch outside the buffered line issues a demand read and stalls the requester until the line arrives.

With prefetch enabled and at least one wait state configured, the block starts reading the next sequential line as soon as a line becomes current. The wait states of that read overlap with the cycles the CPU spends consuming the current line. A fetch that leaves the sequence, such as a branch, abandons any prefetch and reads its own target line. A small control register holds the wait-state count and the prefetch enable. A new wait-state count is only switched in while no array read is running, and the read-back value always shows the count in use.

The fetch request port is valid/ready. A request transfers on a clock edge where `f_valid` and `f_ready` are both high, and `f_addr`/`f_half` must be held stable while `f_valid` waits for `f_ready`. The block holds `f_ready` low from the acceptance of a fetch that cannot be answered at once until its response is issued. The response side has no ready: `rsp_valid` is a one-cycle pulse that the requester must take. The array port is a one-cycle read strobe with a line address. Read data must be valid from the cycle that lies the configured number of wait states after the strobe cycle.

Top module: `flash_pf_ctrl`

## Requirements
- R1: After reset, `f_ready` is 1, `rsp_valid` and `fl_rd` are 0, and the read-back wait-state count and prefetch enable are both 0.
- R2: A fetch whose line (address bits [31:4]) equals the buffered current line gets its response in the cycle after acceptance, and no array strobe is issued for it.
- R3: A fetch that hits neither the current line, the completed prefetch line nor an in-flight prefetch issues one strobe with its line address in the cycle after acceptance. Its response appears WS+2 cycles after the acceptance edge, where WS is the wait-state count, and carries data sampled WS cycles after the strobe cycle.
- R4: A word fetch (`f_half`=0) returns line bits [32*w+31:32*w] with w = address bits [3:2]. A halfword fetch (`f_half`=1) returns line bits [16*k+15:16*k] with k = address bits [3:1], zero-extended to 32 bits. Requests have address bit 0 clear.
- R5: With prefetch enabled and WS of 1 to 3, a line becoming current starts a read of the next line. When the CPU spends four single-cycle fetches on a line, the first fetch of the following line is answered one cycle after acceptance.
- R6: With WS equal to 0, the prefetch enable has no effect: fetch timing, data and strobe count are the same with it on or off.
- R7: A fetch that misses while a prefetch is in flight restarts the array read at its own line and gets a response WS+2 cycles after acceptance. The abandoned prefetched line is not kept: a later fetch of it is a full miss.
- R8: A wait-state write made while the array is idle shows in read-back on the next cycle. One made during a read keeps the old count, both in read-back and for that read, and switches in once the array is idle.
- R9: The prefetch enable read-back follows a write on the next cycle, and with prefetch off a fetch of the next sequential line is a full miss.
- R10: `f_ready` is 0 while a fetch waits for the array, and `rsp_valid` stays high for exactly one cycle per response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_lat_in | input | LAT_W | Wait-state count to write |
| cfg_pf_in | input | 1 | Prefetch enable to write |
| cfg_lat_out | output | LAT_W | Wait-state count in use |
| cfg_pf_out | output | 1 | Prefetch enable in use |
| f_valid | input | 1 | Fetch request valid |
| f_ready | output | 1 | Fetch request can be accepted |
| f_addr | input | ADDR_W | Fetch byte address |
| f_half | input | 1 | 1 = halfword fetch, 0 = word fetch |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Fetched instruction bits |
| fl_rd | output | 1 | Array read strobe, one cycle |
| fl_addr | output | ADDR_W-4 | Array line address |
| fl_rdata | input | LINE_W | Array line data |

## Verification
A stale or wrong current-line tag shows at the ports right away. Either a strobe appears for a fetch that should hit, or a one-cycle response carries another line's bits. The array model returns poison data before the wait states have elapsed, so a read counter loaded with the wrong count yields corrupt data on the very response that depends on it. A prefetch buffer that survives a branch, or a prefetch that slips in at zero wait states, shows up as a response arriving earlier or later than the counted WS+2 cycles on the next fetch of that line. A wait-state count switched in mid-read corrupts the same response and shows in read-back one cycle early.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // where a response takes its line from
  typedef enum logic [1:0] {
    SRC_CUR = 2'd0,
    SRC_PFB = 2'd1,
    SRC_ARR = 2'd2
  } fpc_src_e;
endpackage

// File: rtl/fpc_cfg.sv
module fpc_cfg #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LAT_W-1:0] lat_wr,
  input  logic             pf_wr,
  input  logic             rd_idle,
  output logic [LAT_W-1:0] lat_cur,
  output logic             pf_en
);
  logic [LAT_W-1:0] lat_q, lat_new_q;
  logic             new_pend_q, pf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q      <= '0;
      lat_new_q  <= '0;
      new_pend_q <= 1'b0;
      pf_q       <= 1'b0;
    end else if (we) begin
      pf_q <= pf_wr;
      if (rd_idle) begin
        lat_q      <= lat_wr;
        new_pend_q <= 1'b0;
      end else begin
        lat_new_q  <= lat_wr;
        new_pend_q <= 1'b1;
      end
    end else if (new_pend_q && rd_idle) begin
      lat_q      <= lat_new_q;
      new_pend_q <= 1'b0;
    end
  end

  assign lat_cur = lat_q;
  assign pf_en   = pf_q;

  // R8: the count in use only moves across an edge where the array was idle
  p_lat_switch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q != $past(lat_q)) |-> $past(rd_idle));
endmodule

// File: rtl/fpc_rd_eng.sv
module fpc_rd_eng #(
  parameter int LA_W  = 28,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LA_W-1:0]  start_line,
  input  logic             start_pf,
  input  logic [LAT_W-1:0] lat,
  output logic             busy,
  output logic             cap,
  output logic             is_pf,
  output logic             strobe,
  output logic [LA_W-1:0]  line
);
  logic [LAT_W-1:0] cnt_q;

  // a new start always wins, which is how an in-flight read is abandoned
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      line   <= '0;
      is_pf  <= 1'b0;
      strobe <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt_q  <= lat;
      line   <= start_line;
      is_pf  <= start_pf;
      strobe <= 1'b1;
    end else begin
      strobe <= 1'b0;
      if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cap = busy && (cnt_q == '0);

  // R3: the wait counter never exceeds the count it was loaded from
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= lat));
  // R3: the strobe cycle is the first cycle of a read, with the full count loaded
  p_strobe_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (busy && cnt_q == lat));
endmodule

// File: rtl/fpc_sel.sv
module fpc_sel #(
  parameter int LINE_W = 128,
  parameter int HI_W   = 3
) (
  input  logic [LINE_W-1:0] line,
  input  logic [HI_W-1:0]   hidx,
  input  logic              half,
  output logic [31:0]       data
);
  localparam int NH = LINE_W / 16;

  logic [15:0] halves [NH];

  for (genvar g = 0; g < NH; g++) begin : g_split
    assign halves[g] = line[16*g +: 16];
  end

  logic [HI_W-2:0] widx;
  assign widx = hidx[HI_W-1:1];

  always_comb begin
    if (half) data = {16'h0000, halves[hidx]};
    else      data = {halves[{widx, 1'b1}], halves[{widx, 1'b0}]};
  end
endmodule

// File: rtl/flash_pf_ctrl.sv
module flash_pf_ctrl #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int LAT_W  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [LAT_W-1:0]                       cfg_lat_in,
  input  logic                                   cfg_pf_in,
  output logic [LAT_W-1:0]                       cfg_lat_out,
  output logic                                   cfg_pf_out,
  input  logic                                   f_valid,
  output logic                                   f_ready,
  input  logic [ADDR_W-1:0]                      f_addr,
  input  logic                                   f_half,
  output logic                                   rsp_valid,
  output logic [31:0]                            rsp_data,
  output logic                                   fl_rd,
  output logic [ADDR_W-$clog2(LINE_W/8)-1:0]     fl_addr,
  input  logic [LINE_W-1:0]                      fl_rdata
);
  import fpc_pkg::*;

  localparam int OFF_W = $clog2(LINE_W / 8);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int HI_W  = OFF_W - 1;

  // configuration
  logic [LAT_W-1:0] lat_cur;
  logic             pf_en, pf_act;

  // read engine
  logic             e_busy, e_cap, e_pf, e_strobe;
  logic [LA_W-1:0]  e_line;

  // line buffers and pending request
  logic              cur_v, pf_v, pend;
  logic [LA_W-1:0]   cur_line, pf_line, pend_line;
  logic [LINE_W-1:0] cur_data, pf_data;
  logic [HI_W-1:0]   pend_hidx;
  logic              pend_half;
  logic              rsp_v_q;
  logic [31:0]       rsp_q;

  // request decode
  logic             acc, hit_cur, hit_pfb, hit_inf;
  logic [LA_W-1:0]  req_line;
  logic [HI_W-1:0]  req_hidx;

  // decisions
  logic             go_rsp, use_req, cur_ld, cur_from_arr;
  logic             st, st_pf, pend_set, pend_clr, pfv_clr, pf_store;
  logic [LA_W-1:0]  st_line;
  fpc_src_e         src;

  logic [LINE_W-1:0] sel_line;
  logic [31:0]       sel_out;

  assign pf_act   = pf_en && (lat_cur != '0);
  assign f_ready  = !pend;
  assign acc      = f_valid && f_ready;
  assign req_line = f_addr[ADDR_W-1:OFF_W];
  assign req_hidx = f_addr[OFF_W-1:1];
  assign hit_cur  = cur_v && (req_line == cur_line);
  assign hit_pfb  = pf_v && (req_line == pf_line);
  assign hit_inf  = e_busy && e_pf && (e_line == req_line);

  always_comb begin
    go_rsp       = 1'b0;
    use_req      = 1'b1;
    src          = SRC_CUR;
    cur_ld       = 1'b0;
    cur_from_arr = 1'b0;
    st           = 1'b0;
    st_pf        = 1'b0;
    st_line      = req_line;
    pend_set     = 1'b0;
    pend_clr     = 1'b0;
    pfv_clr      = 1'b0;
    if (acc) begin
      if (hit_cur) begin
        go_rsp = 1'b1;
      end else if (hit_pfb) begin
        go_rsp  = 1'b1;
        src     = SRC_PFB;
        cur_ld  = 1'b1;
        pfv_clr = 1'b1;
        st      = pf_act;
        st_pf   = 1'b1;
        st_line = req_line + LA_W'(1);
      end else if (hit_inf && e_cap) begin
        go_rsp       = 1'b1;
        src          = SRC_ARR;
        cur_ld       = 1'b1;
        cur_from_arr = 1'b1;
        st           = pf_act;
        st_pf        = 1'b1;
        st_line      = req_line + LA_W'(1);
      end else if (hit_inf) begin
        pend_set = 1'b1;
      end else begin
        st       = 1'b1;
        pend_set = 1'b1;
        pfv_clr  = 1'b1;
      end
    end else if (pend && e_cap && (e_line == pend_line)) begin
      go_rsp       = 1'b1;
      use_req      = 1'b0;
      src          = SRC_ARR;
      cur_ld       = 1'b1;
      cur_from_arr = 1'b1;
      pend_clr     = 1'b1;
      st           = pf_act;
      st_pf        = 1'b1;
      st_line      = pend_line + LA_W'(1);
    end
  end

  assign pf_store = e_cap && e_pf && !cur_from_arr;

  always_comb begin
    case (src)
      SRC_PFB: sel_line = pf_data;
      SRC_ARR: sel_line = fl_rdata;
      default: sel_line = cur_data;
    endcase
  end

  fpc_sel #(.LINE_W(LINE_W), .HI_W(HI_W)) u_sel (
    .line (sel_line),
    .hidx (use_req ? req_hidx : pend_hidx),
    .half (use_req ? f_half : pend_half),
    .data (sel_out)
  );

  fpc_cfg #(.LAT_W(LAT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .lat_wr  (cfg_lat_in),
    .pf_wr   (cfg_pf_in),
    .rd_idle (!e_busy && !st),
    .lat_cur (lat_cur),
    .pf_en   (pf_en)
  );

  fpc_rd_eng #(.LA_W(LA_W), .LAT_W(LAT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (st),
    .start_line (st_line),
    .start_pf   (st_pf),
    .lat        (lat_cur),
    .busy       (e_busy),
    .cap        (e_cap),
    .is_pf      (e_pf),
    .strobe     (e_strobe),
    .line       (e_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q   <= 1'b0;
      rsp_q     <= '0;
      cur_v     <= 1'b0;
      cur_line  <= '0;
      cur_data  <= '0;
      pf_v      <= 1'b0;
      pf_line   <= '0;
      pf_data   <= '0;
      pend      <= 1'b0;
      pend_line <= '0;
      pend_hidx <= '0;
      pend_half <= 1'b0;
    end else begin
      rsp_v_q <= go_rsp;
      if (go_rsp) rsp_q <= sel_out;
      if (pf_store) begin
        pf_v    <= 1'b1;
        pf_line <= e_line;
        pf_data <= fl_rdata;
      end
      if (pfv_clr) pf_v <= 1'b0;
      if (cur_ld) begin
        cur_v    <= 1'b1;
        cur_line <= use_req ? req_line : pend_line;
        cur_data <= cur_from_arr ? fl_rdata : pf_data;
      end
      if (pend_set) begin
        pend      <= 1'b1;
        pend_line <= req_line;
        pend_hidx <= req_hidx;
        pend_half <= f_half;
      end
      if (pend_clr) pend <= 1'b0;
    end
  end

  assign rsp_valid   = rsp_v_q;
  assign rsp_data    = rsp_q;
  assign fl_rd       = e_strobe;
  assign fl_addr     = e_line;
  assign cfg_lat_out = lat_cur;
  assign cfg_pf_out  = pf_en;

  // R2: a hit on the current line never causes an array strobe
  p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit_cur) |=> !fl_rd);
  // R6: a prefetch strobe only goes out with at least one wait state in use
  p_pf_needs_ws_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && e_pf) |-> (lat_cur != '0));
  // R10: no response is presented while a fetch is still waiting
  p_rsp_not_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !pend);
  // R3: every response traces back to an accepted or a waiting fetch
  p_rsp_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(acc) || $past(pend)));
  // R4: fetch addresses are halfword aligned
  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid |-> !f_addr[0]);
endmodule

// File: tb/sim_flash_pf_ctrl.sv
module sim_flash_pf_ctrl;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 128;
  localparam int LAT_W  = 3;
  localparam int LA_W   = 28;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we, cfg_pf_in, cfg_pf_out;
  logic [LAT_W-1:0]  cfg_lat_in, cfg_lat_out;
  logic              f_valid, f_ready, f_half, rsp_valid, fl_rd;
  logic [ADDR_W-1:0] f_addr;
  logic [31:0]       rsp_data;
  logic [LA_W-1:0]   fl_addr;
  logic [LINE_W-1:0] fl_rdata;

  int n_chk = 0;
  int n_err = 0;
  int n_rd  = 0;

  always #5 clk = ~clk;

  flash_pf_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_lat_in(cfg_lat_in), .cfg_pf_in(cfg_pf_in),
    .cfg_lat_out(cfg_lat_out), .cfg_pf_out(cfg_pf_out),
    .f_valid(f_valid), .f_ready(f_ready), .f_addr(f_addr), .f_half(f_half),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  // ---------------- array model ----------------
  function automatic logic [15:0] hw_of(input logic [LA_W-1:0] l, input int k);
    logic [31:0] t;
    t = {4'b0, l} * 32'd8 + 32'(k);
    return t[15:0] ^ 16'hA5C3;
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input logic [LA_W-1:0] l);
    logic [LINE_W-1:0] v;
    for (int k = 0; k < 8; k++) v[16*k +: 16] = hw_of(l, k);
    return v;
  endfunction

  function automatic logic [31:0] exp_of(input logic [31:0] a, input logic h);
    int idx;
    idx = int'(a[3:1]);
    if (h) return {16'h0000, hw_of(a[31:4], idx)};
    return {hw_of(a[31:4], (idx & 6) + 1), hw_of(a[31:4], idx & 6)};
  endfunction

  int              m_ws = 0;
  int              m_age = 1000;
  logic [LA_W-1:0] m_addr = '0;

  always @(posedge clk) begin
    if (fl_rd) begin
      m_addr <= fl_addr;
      m_age  <= 1;
    end else if (m_age < 1000) begin
      m_age <= m_age + 1;
    end
    if (rst_n && fl_rd) n_rd <= n_rd + 1;
  end

  always_comb begin
    if (fl_rd ? (m_ws == 0) : (m_age >= m_ws))
      fl_rdata = line_of(fl_rd ? fl_addr : m_addr);
    else
      fl_rdata = {8{16'hDEAD}};
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int lat, input bit pf);
    repeat (8) @(negedge clk);
    cfg_we = 1'b1; cfg_lat_in = LAT_W'(lat); cfg_pf_in = pf;
    @(negedge clk);
    cfg_we = 1'b0;
    m_ws = lat;
    chk("R8", "idle wait-state write read-back", longint'(cfg_lat_out), longint'(lat));
    chk("R9", "prefetch enable read-back", longint'(cfg_pf_out), longint'(pf));
  endtask

  // called at a negedge; returns at the negedge where the response is seen
  task automatic do_fetch(input logic [31:0] a, input logic h, input int exp_cyc,
                          input string req, output int cyc);
    f_addr = a; f_half = h; f_valid = 1'b1;
    while (!f_ready) @(negedge clk);
    @(negedge clk);
    f_valid = 1'b0;
    cyc = 1;
    if (exp_cyc > 1) chk("R10", "ready low while waiting", longint'(f_ready), 0);
    while (!rsp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    chk(req, "response data", longint'(rsp_data), longint'(exp_of(a, h)));
    if (exp_cyc > 0) chk(req, "response cycles", longint'(cyc), longint'(exp_cyc));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_lat_in = '0; cfg_pf_in = 1'b0;
    f_valid = 1'b0; f_addr = '0; f_half = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", longint'(f_ready), 1);
    chk("R1", "no response after reset", longint'(rsp_valid), 0);
    chk("R1", "no strobe after reset", longint'(fl_rd), 0);
    chk("R1", "wait states after reset", longint'(cfg_lat_out), 0);
    chk("R1", "prefetch after reset", longint'(cfg_pf_out), 0);
  endtask

  task automatic t_select();
    int c, r0;
    set_cfg(1, 1'b0);
    r0 = n_rd;
    do_fetch(32'h0000_2000, 1'b0, 3, "R3", c);
    chk("R3", "one strobe for a miss", longint'(n_rd - r0), 1);
    for (int k = 0; k < 8; k++) do_fetch(32'h0000_2000 + 32'(2*k), 1'b1, 1, "R4", c);
    for (int w = 1; w < 4; w++) do_fetch(32'h0000_2000 + 32'(4*w), 1'b0, 1, "R4", c);
    chk("R2", "no strobe for hits", longint'(n_rd - r0), 1);
  endtask

  // four single-cycle fetches on a line, then the first of the next line
  task automatic seq_line(input logic [31:0] base, input int lat, input int exp_next, input string req);
    int c;
    do_fetch(base, 1'b0, lat + 2, "R3", c);
    for (int w = 1; w < 4; w++) do_fetch(base + 32'(4*w), 1'b0, 1, "R2", c);
    do_fetch(base + 32'h10, 1'b0, exp_next, req, c);
    do_fetch(base + 32'h14, 1'b0, 1, "R2", c);
  endtask

  task automatic t_prefetch();
    for (int l = 1; l <= 3; l++) begin
      set_cfg(l, 1'b1);
      seq_line(32'h0000_4000 + 32'(l * 32'h100), l, 1, "R5");
    end
  endtask

  task automatic t_no_pf();
    set_cfg(3, 1'b0);
    seq_line(32'h0000_5000, 3, 5, "R9");
  endtask

  task automatic t_ws0();
    int cy [2][5];
    int rd [2];
    logic [31:0] ad [5];
    logic        hh [5];
    int          ex [5];
    ad = '{32'h0000_6000, 32'h0000_6004, 32'h0000_6010, 32'h0000_601C, 32'h0000_6058};
    hh = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    ex = '{2, 1, 2, 1, 2};
    for (int p = 0; p < 2; p++) begin
      int r0;
      set_cfg(0, p[0]);
      r0 = n_rd;
      for (int i = 0; i < 5; i++) do_fetch(ad[i], hh[i], ex[i], "R6", cy[p][i]);
      repeat (6) @(negedge clk);
      rd[p] = n_rd - r0;
    end
    for (int i = 0; i < 5; i++)
      chk("R6", "same timing with prefetch on", longint'(cy[1][i]), longint'(cy[0][i]));
    chk("R6", "same strobe count with prefetch on", longint'(rd[1]), longint'(rd[0]));
  endtask

  task automatic t_branch();
    int c;
    set_cfg(3, 1'b1);
    do_fetch(32'h0000_1000, 1'b0, 5, "R3", c);
    do_fetch(32'h0000_9008, 1'b0, 5, "R7", c);
    do_fetch(32'h0000_1010, 1'b0, 5, "R7", c);
  endtask

  task automatic t_latchg();
    int c;
    set_cfg(3, 1'b0);
    f_addr = 32'h0000_7000; f_half = 1'b0; f_valid = 1'b1;
    while (!f_ready) @(negedge clk);
    @(negedge clk);
    f_valid = 1'b0;
    cfg_we = 1'b1; cfg_lat_in = 3'd1; cfg_pf_in = 1'b0;
    c = 1;
    @(negedge clk);
    cfg_we = 1'b0;
    c++;
    chk("R8", "old count during read", longint'(cfg_lat_out), 3);
    while (!rsp_valid && c < 60) begin
      @(negedge clk);
      c++;
    end
    chk("R8", "read keeps old count (data)", longint'(rsp_data), longint'(exp_of(32'h0000_7000, 1'b0)));
    chk("R8", "read keeps old count (cycles)", longint'(c), 5);
    chk("R8", "old count at response", longint'(cfg_lat_out), 3);
    @(negedge clk);
    chk("R10", "response is a single-cycle pulse", longint'(rsp_valid), 0);
    chk("R8", "new count once idle", longint'(cfg_lat_out), 1);
    m_ws = 1;
    do_fetch(32'h0000_7100, 1'b0, 3, "R8", c);
  endtask

  // ---------------- run ----------------
  initial begin
    t_reset();
    t_select();
    t_prefetch();
    t_no_pf();
    t_ws0();
    t_branch();
    t_latchg();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule